// File: doc/BRIEF.md
# Faulty-Block Remap Table

This block is a small fully associative lookup table that steers cache accesses away from defective blocks. Each of its entries pairs the full index of a cache block that failed test with the column address of a healthy block in the same row. A test pass loads the entries through a configuration write port. During normal operation every cache access presents its index. All valid entries compare against that index in parallel, in the same cycle.

When one entry matches, the block raises a hit flag and drives out the stored substitute column, which it selects through a one-hot multiplexer steered by the per-entry match lines. When nothing matches, the requester's own column passes through unchanged, so the column multiplexer of the cache can always take its select from this block. The number of entries sets how many faulty blocks can be tolerated. A full flag shows when no free entry remains, and a sticky overflow flag records a write that was refused for lack of space.

Top module: `fault_remap_cam`

## Requirements
- R1: When a valid entry holds the presented lookup index, `hit` is 1 and `outCol` equals that entry's stored column in the same cycle, with no register in the lookup path. At most one entry matches any index.
- R2: When no valid entry holds the lookup index, `hit` is 0 and `outCol` equals `reqCol`.
- R3: A write (`testMode`=1, `wrEn`=1, `clearAll`=0) whose index is not stored, made while a free entry exists, stores the index/column pair in one free entry at the next clock edge.
- R4: A write whose index is already stored replaces that entry's column and consumes no further entry.
- R5: `full` is 1 exactly when every entry holds a valid pair.
- R6: A write of an index that is not stored, made while `full` is 1, is refused: the index still misses, existing entries keep their columns, and `overflow` becomes 1 at the next edge.
- R7: Once set, `overflow` stays 1 until a clear is accepted.
- R8: A clear (`testMode`=1, `clearAll`=1) invalidates every entry and drops `full` and `overflow` at the next edge. A clear takes priority over a write presented in the same cycle.
- R9: When `testMode` is 0, `wrEn` and `clearAll` have no effect on the table, `full` or `overflow`.
- R10: After reset, all entries are invalid and `hit`, `full` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| testMode | input | 1 | Enables writes and clears |
| clearAll | input | 1 | Invalidate all entries (test mode only) |
| wrEn | input | 1 | Write request (test mode only) |
| wrIndex | input | IDX_W | Faulty block index to store |
| wrCol | input | COL_W | Substitute column for that index |
| lkIndex | input | IDX_W | Index of the current access |
| reqCol | input | COL_W | Column the access would use unremapped |
| hit | output | 1 | Lookup index found in the table |
| outCol | output | COL_W | Column to use for the access |
| full | output | 1 | No free entry remains |
| overflow | output | 1 | Sticky: a write was refused for lack of space |

## Verification
On every cycle the assertions check that no more than one match line is active, that an update leaves the fill state unchanged, that a refused write sets the overflow flag, that the overflow flag holds until cleared, that a clear empties the table, and that nothing changes outside test mode. Only the bench's scenarios can show the actual contents: which indices hit, which column comes back, and that a refused or ignored write leaves every other index untouched. The bench shows this by sweeping the whole index space after each configuration step.

// File: rtl/fault_cam_pkg.sv
package fault_cam_pkg;
  // Strobes from control to the entry store
  typedef struct packed {
    logic wipe;    // invalidate every entry
    logic load;    // write the entry selected by loadSel
    logic setOvf;  // write refused
  } camStrobe_t;
endpackage

// File: rtl/fault_cam_ctrl.sv
module fault_cam_ctrl
  import fault_cam_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               testMode,
  input  logic               clearAll,
  input  logic               wrEn,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] wrHitVec,
  output camStrobe_t         strb,
  output logic [ENTRIES-1:0] loadSel,
  output logic               overflow
);
  logic [ENTRIES-1:0] firstFree;
  logic               anyFree;
  logic               ovfQ;

  // Lowest-numbered free entry, one-hot
  always_comb begin
    firstFree = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        firstFree = '0;
        firstFree[i] = 1'b1;
      end
    end
  end

  assign anyFree = ~&validVec;

  always_comb begin
    strb        = '0;
    loadSel     = '0;
    strb.wipe   = testMode & clearAll;
    if (testMode && !clearAll && wrEn) begin
      if (|wrHitVec) begin
        strb.load = 1'b1;
        loadSel   = wrHitVec;
      end else if (anyFree) begin
        strb.load = 1'b1;
        loadSel   = firstFree;
      end else begin
        strb.setOvf = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ovfQ <= 1'b0;
    else if (strb.wipe)   ovfQ <= 1'b0;
    else if (strb.setOvf) ovfQ <= 1'b1;
  end

  assign overflow = ovfQ;
endmodule

// File: rtl/fault_cam_store.sv
module fault_cam_store
  import fault_cam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 6,
  parameter int COL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  camStrobe_t         strb,
  input  logic [ENTRIES-1:0] loadSel,
  input  logic [IDX_W-1:0]   wrIndex,
  input  logic [COL_W-1:0]   wrCol,
  input  logic [IDX_W-1:0]   lkIndex,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] wrHitVec,
  output logic [ENTRIES-1:0] lkHitVec,
  output logic [COL_W-1:0]   storedCol
);
  logic [COL_W-1:0] colVec [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic [IDX_W-1:0] tagQ;
    logic [COL_W-1:0] colQ;
    logic             vldQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldQ <= 1'b0;
        tagQ <= '0;
        colQ <= '0;
      end else if (strb.wipe) begin
        vldQ <= 1'b0;
      end else if (strb.load && loadSel[g]) begin
        vldQ <= 1'b1;
        tagQ <= wrIndex;
        colQ <= wrCol;
      end
    end

    assign validVec[g] = vldQ;
    assign wrHitVec[g] = vldQ && (tagQ == wrIndex);
    assign lkHitVec[g] = vldQ && (tagQ == lkIndex);
    assign colVec[g]   = colQ;
  end

  // One-hot AND-OR multiplexer on the match lines
  always_comb begin
    storedCol = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      storedCol = storedCol | ({COL_W{lkHitVec[i]}} & colVec[i]);
    end
  end
endmodule

// File: rtl/fault_remap_cam.sv
module fault_remap_cam
  import fault_cam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 6,
  parameter int COL_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testMode,
  input  logic             clearAll,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic [COL_W-1:0] wrCol,
  input  logic [IDX_W-1:0] lkIndex,
  input  logic [COL_W-1:0] reqCol,
  output logic             hit,
  output logic [COL_W-1:0] outCol,
  output logic             full,
  output logic             overflow
);
  camStrobe_t         strb;
  logic [ENTRIES-1:0] loadSel;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] wrHitVec;
  logic [ENTRIES-1:0] lkHitVec;
  logic [COL_W-1:0]   storedCol;

  fault_cam_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .clearAll(clearAll),
    .wrEn(wrEn), .validVec(validVec), .wrHitVec(wrHitVec),
    .strb(strb), .loadSel(loadSel), .overflow(overflow)
  );

  fault_cam_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .COL_W(COL_W)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .loadSel(loadSel),
    .wrIndex(wrIndex), .wrCol(wrCol), .lkIndex(lkIndex),
    .validVec(validVec), .wrHitVec(wrHitVec), .lkHitVec(lkHitVec),
    .storedCol(storedCol)
  );

  assign hit    = |lkHitVec;
  assign outCol = hit ? storedCol : reqCol;
  assign full   = &validVec;
endmodule

// File: rtl/fault_cam_chk.sv
module fault_cam_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               testMode,
  input logic               clearAll,
  input logic               wrEn,
  input logic               hit,
  input logic               full,
  input logic               overflow,
  input logic [ENTRIES-1:0] lkHitVec,
  input logic [ENTRIES-1:0] wrHitVec
);
  // R1: never more than one match line
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHitVec));

  // R4: an in-place update does not change the fill state
  a_r4_update_in_place: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && wrEn && !clearAll && (|wrHitVec)) |=> $stable(full));

  // R6: a new index written into a full table is refused
  a_r6_refuse_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && wrEn && !clearAll && full && !(|wrHitVec)) |=> (overflow && full));

  // R7: overflow holds until a clear
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !(testMode && clearAll)) |=> overflow);

  // R8: clear empties the table
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && clearAll) |=> (!full && !overflow && !hit));

  // R9: nothing changes outside test mode
  a_r9_no_effect_outside_test: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |=> ($stable(full) && $stable(overflow)));
endmodule

bind fault_remap_cam fault_cam_chk #(.ENTRIES(ENTRIES)) uChk (
  .clk(clk), .rstN(rstN), .testMode(testMode), .clearAll(clearAll),
  .wrEn(wrEn), .hit(hit), .full(full), .overflow(overflow),
  .lkHitVec(lkHitVec), .wrHitVec(wrHitVec)
);

// File: tb/tb_fault_remap_cam.sv
`timescale 1ns/1ps
module tb_fault_remap_cam;
  localparam int ENTRIES = 8;
  localparam int IDX_W   = 6;
  localparam int COL_W   = 2;
  localparam int NIDX    = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testMode = 1'b0, clearAll = 1'b0, wrEn = 1'b0;
  logic [IDX_W-1:0] wrIndex = '0, lkIndex = '0;
  logic [COL_W-1:0] wrCol = '0, reqCol = '0;
  logic hit, full, overflow;
  logic [COL_W-1:0] outCol;

  always #2 clk = ~clk;  // 250 MHz

  fault_remap_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .COL_W(COL_W)) dut (
    .clk(clk), .rstN(rstN), .testMode(testMode), .clearAll(clearAll),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrCol(wrCol), .lkIndex(lkIndex),
    .reqCol(reqCol), .hit(hit), .outCol(outCol), .full(full), .overflow(overflow)
  );

  // Reference model
  bit               mVal [NIDX];
  logic [COL_W-1:0] mCol [NIDX];
  int               mCnt = 0;
  bit               mOvf = 0;

  int nChk = 0, nErr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock of configuration traffic, model updated per R3/R4/R6/R8/R9
  task automatic op(input bit tm, input bit clr, input bit we,
                    input int idx, input int col);
    @(negedge clk);
    testMode = tm; clearAll = clr; wrEn = we;
    wrIndex = IDX_W'(idx); wrCol = COL_W'(col);
    if (tm && clr) begin
      for (int i = 0; i < NIDX; i++) mVal[i] = 0;
      mCnt = 0; mOvf = 0;
    end else if (tm && we) begin
      if (mVal[idx]) mCol[idx] = COL_W'(col);
      else if (mCnt < ENTRIES) begin
        mVal[idx] = 1; mCol[idx] = COL_W'(col); mCnt++;
      end else mOvf = 1;
    end
    @(negedge clk);
    testMode = 0; clearAll = 0; wrEn = 0;
  endtask

  // Full sweep of the index space plus flag checks
  task automatic sweep(input string phase);
    for (int i = 0; i < NIDX; i++) begin
      logic [COL_W-1:0] rc, expCol;
      rc = COL_W'((i * 3 + 1) % (1 << COL_W));
      lkIndex = IDX_W'(i); reqCol = rc;
      #1;
      expCol = mVal[i] ? mCol[i] : rc;
      if (mVal[i]) begin
        chk(hit === 1'b1, {phase, " R1 hit"}, int'(hit), 1);
        chk(outCol === expCol, {phase, " R1 column"}, int'(outCol), int'(expCol));
      end else begin
        chk(hit === 1'b0, {phase, " R2 miss"}, int'(hit), 0);
        chk(outCol === expCol, {phase, " R2 passthrough"}, int'(outCol), int'(expCol));
      end
    end
    chk(full === (mCnt == ENTRIES), {phase, " R5 full"}, int'(full), int'(mCnt == ENTRIES));
    chk(overflow === mOvf, {phase, " R7 overflow"}, int'(overflow), int'(mOvf));
  endtask

  initial begin
    for (int i = 0; i < NIDX; i++) begin mVal[i] = 0; mCol[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sweep("reset R10");

    // R3: distinct indices into free entries
    for (int k = 0; k < 5; k++) op(1, 0, 1, k * 7 + 3, k % 4);
    sweep("alloc R3");

    // R4: rewrite existing index with a new column
    op(1, 0, 1, 10, 3);
    op(1, 0, 1, 3, 2);
    sweep("update R4");

    // R5: fill to capacity
    for (int k = 0; k < 3; k++) op(1, 0, 1, 40 + k * 5, (k + 1) % 4);
    sweep("fill R5");

    // R6: refused write when full, then update still accepted
    op(1, 0, 1, 63, 1);
    sweep("refuse R6");
    op(1, 0, 1, 50, 0);
    sweep("update-full R6");

    // R9: clear and writes outside test mode ignored
    op(0, 1, 0, 0, 0);
    op(0, 0, 1, 17, 2);
    sweep("idle R9");

    // R7: overflow still held after idle cycles
    repeat (5) @(negedge clk);
    sweep("sticky R7");

    // R8: clear with a simultaneous write, clear wins
    op(1, 1, 1, 22, 1);
    sweep("clear R8");

    // R9: write outside test mode after clear stays out
    op(0, 0, 1, 22, 1);
    sweep("idle-empty R9");

    // R3/R5 refill with a new pattern
    for (int k = 0; k < ENTRIES; k++) op(1, 0, 1, 63 - k * 2, (k * 3) % 4);
    sweep("refill R5");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end
endmodule